// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of a dual-slope integrating converter. It runs a fixed-length measurement cycle made of four phases: auto-zero, signal integrate, reference deintegrate and integrator zeroing. For each phase it drives exactly one analog switch control. The comparator level is registered once per clock. The sequencer latches the input polarity at the end of integration and counts deintegrate clocks in BCD until the comparator reports a zero crossing.

At the end of each conversion the block issues a one-clock result-valid pulse together with the held five-digit reading. It also drives the busy, polarity, over-range and under-range flags, each of which sets and clears at fixed phase boundaries. A run/hold input selects between continuous conversion and single conversions. In single mode, a rising edge seen while idle starts one new cycle.

Top module: `ds_sequencer`

## Requirements
- R1: With run high, auto-zero lasts AZ_CLKS clocks (default 10001) and signal integrate lasts INT_CLKS clocks (default 10000). The whole cycle lasts AZ_CLKS+INT_CLKS+DEINT_MAX clocks (default 40002), so consecutive rises of the integrate switch are that many clocks apart.
- R2: Deintegrate clocks are numbered from 0. If the comparator input first differs from the latched polarity in deintegrate clock N, the reading is N, because the first deintegrate clock is not counted. The reading is BCD, 4 bits per digit, with the least significant digit in bits [3:0].
- R3: If no crossing is detected within DEINT_MAX deintegrate clocks, the reading is full scale (DEINT_MAX-1, default 20000) and over_o rises when busy falls. A crossing detected on the final deintegrate edge counts as an ordinary conversion, not an over-range.
- R4: busy_o rises on the first clock of signal integrate. It falls N+2 clocks after deintegrate starts for a crossing in clock N, or at the end of the cycle on over-range.
- R5: valid_o is a single-clock pulse in the clock where busy falls. result_o changes only in that clock.
- R6: over_o stays high through the next auto-zero and integrate phases and clears on the first clock of the next deintegrate.
- R7: under_o rises when busy falls if the reading is at most UNDER_LIMIT (default 1800). It clears on the first clock of the next signal integrate.
- R8: pol_o (1 = positive) takes the comparator level of the last integrate clock and changes only on the first clock of deintegrate.
- R9: The four switch outputs are registered and exactly one is high at any time. The auto-zero switch is also high while the block is idle and in reset. In reset, busy, valid and the flags are 0 and the result is zero.
- R10: If run is low at the end of a cycle, the sequencer idles with auto-zero active, starts no integration, and keeps its result and flags.
- R11: While idle, a rising edge on run starts exactly one cycle. A run pulse that comes and goes inside a cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run (high) / hold (low), asynchronous, synchronized inside |
| cmp_i | input | 1 | Comparator level, 1 = integrator on the positive side |
| sw_az_o | output | 1 | Auto-zero switch control |
| sw_int_o | output | 1 | Signal integrate switch control |
| sw_deint_o | output | 1 | Reference deintegrate switch control |
| sw_zero_o | output | 1 | Integrator zeroing switch control |
| busy_o | output | 1 | High from integrate start until conversion end |
| pol_o | output | 1 | Input polarity of the last conversion |
| over_o | output | 1 | Over-range flag |
| under_o | output | 1 | Under-range flag |
| result_o | output | 4*RES_DIGITS | BCD reading |
| valid_o | output | 1 | One-clock pulse when a new reading is presented |

## Verification
The bench runs the block with a short cycle (11 + 10 + 21 clocks) and times every result from the first sampled deintegrate clock. Busy must fall and valid must pulse exactly N+2 clocks after a comparator change in deintegrate clock N. Polarity and the over-range clear are checked on that first deintegrate clock, and the under-range clear is checked on the first integrate clock. The comparator is driven at the falling edge so that each level is sampled in the intended clock. Expected readings are queued before a cycle starts and compared only when the valid pulse appears. The idle checks look at the ports over 150 clocks after the cycle has ended.

// File: rtl/ds_seq_pkg.sv
package ds_seq_pkg;

    typedef enum logic [2:0] {
        PH_AZ    = 3'd0,
        PH_INT   = 3'd1,
        PH_DEINT = 3'd2,
        PH_ZERO  = 3'd3,
        PH_HOLD  = 3'd4
    } phase_e;

    localparam int SW_AZ    = 0;
    localparam int SW_INT   = 1;
    localparam int SW_DEINT = 2;
    localparam int SW_ZERO  = 3;

    // Switch pattern for a phase; idle keeps the auto-zero loop closed.
    function automatic logic [3:0] sw_of(input phase_e ph);
        logic [3:0] s;
        s = '0;
        case (ph)
            PH_INT:   s[SW_INT]   = 1'b1;
            PH_DEINT: s[SW_DEINT] = 1'b1;
            PH_ZERO:  s[SW_ZERO]  = 1'b1;
            default:  s[SW_AZ]    = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ds_run_sync.sv
module ds_run_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic armed_i,
    output logic level_o,
    output logic rise_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], run_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign level_o = sh_q[SYNC_STAGES-1];
    // Edge detection only counts while the sequencer waits in idle.
    assign rise_o  = armed_i & sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

endmodule

// File: rtl/ds_bcd_inc.sv
module ds_bcd_inc #(
    parameter int DIGITS = 5
) (
    input  logic [4*DIGITS-1:0] val_i,
    output logic [4*DIGITS-1:0] inc_o
);
    logic [DIGITS:0] carry;

    assign carry[0] = 1'b1;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [3:0] dig;
        logic       is_nine;
        assign dig        = val_i[4*g +: 4];
        assign is_nine    = (dig == 4'd9);
        assign carry[g+1] = carry[g] & is_nine;
        assign inc_o[4*g +: 4] = !carry[g] ? dig :
                                 (is_nine ? 4'd0 : dig + 4'd1);
    end

endmodule

// File: rtl/ds_sequencer.sv
module ds_sequencer
    import ds_seq_pkg::*;
#(
    parameter int AZ_CLKS     = 10001,
    parameter int INT_CLKS    = 10000,
    parameter int DEINT_MAX   = 20001,
    parameter int UNDER_LIMIT = 1800,
    parameter int RES_DIGITS  = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    run_i,
    input  logic                    cmp_i,
    output logic                    sw_az_o,
    output logic                    sw_int_o,
    output logic                    sw_deint_o,
    output logic                    sw_zero_o,
    output logic                    busy_o,
    output logic                    pol_o,
    output logic                    over_o,
    output logic                    under_o,
    output logic [4*RES_DIGITS-1:0] result_o,
    output logic                    valid_o
);
    localparam int CYC_LEN = AZ_CLKS + INT_CLKS + DEINT_MAX;
    localparam int CW      = $clog2(CYC_LEN);
    localparam int BW      = $clog2(DEINT_MAX + 1);
    localparam int RW      = 4 * RES_DIGITS;

    localparam logic [CW-1:0] AZ_LAST   = CW'(AZ_CLKS - 1);
    localparam logic [CW-1:0] INT_LAST  = CW'(AZ_CLKS + INT_CLKS - 1);
    localparam logic [CW-1:0] DE_FIRST  = CW'(AZ_CLKS + INT_CLKS);
    localparam logic [CW-1:0] CYC_LAST  = CW'(CYC_LEN - 1);
    localparam logic [BW-1:0] UNDER_CMP = BW'(UNDER_LIMIT);

    typedef struct packed {
        phase_e          ph;
        logic [3:0]      sw;
        logic [CW-1:0]   cyc;
        logic            cmp;
        logic            pol;
        logic [RW-1:0]   bcd;
        logic [BW-1:0]   bin;
        logic [RW-1:0]   res;
        logic            busy;
        logic            over;
        logic            under;
        logic            valid;
    } seq_t;

    seq_t d, q;

    logic          run_lvl;
    logic          run_rise;
    logic [RW-1:0] bcd_next;

    ds_run_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_run_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run_i),
        .armed_i (q.ph == PH_HOLD),
        .level_o (run_lvl),
        .rise_o  (run_rise)
    );

    ds_bcd_inc #(
        .DIGITS(RES_DIGITS)
    ) u_bcd_inc (
        .val_i (q.bcd),
        .inc_o (bcd_next)
    );

    always_comb begin
        logic at_end;
        logic crossed;
        logic cnt_en;

        d       = q;
        d.valid = 1'b0;
        d.cmp   = cmp_i;

        at_end  = (q.cyc == CYC_LAST);
        crossed = (q.cmp != q.pol);
        // The late comparator sample is offset by skipping the first count.
        cnt_en  = (q.cyc != DE_FIRST);

        case (q.ph)
            PH_AZ: begin
                d.cyc = q.cyc + 1'b1;
                if (q.cyc == AZ_LAST) begin
                    d.ph    = PH_INT;
                    d.busy  = 1'b1;
                    d.under = 1'b0;
                end
            end
            PH_INT: begin
                d.cyc = q.cyc + 1'b1;
                if (q.cyc == INT_LAST) begin
                    d.ph   = PH_DEINT;
                    d.pol  = q.cmp;
                    d.over = 1'b0;
                    d.bcd  = '0;
                    d.bin  = '0;
                end
            end
            PH_DEINT: begin
                d.cyc = q.cyc + 1'b1;
                if (crossed) begin
                    d.ph    = PH_ZERO;
                    d.busy  = 1'b0;
                    d.valid = 1'b1;
                    d.res   = q.bcd;
                    d.over  = 1'b0;
                    d.under = (q.bin <= UNDER_CMP);
                end else begin
                    if (cnt_en) begin
                        d.bcd = bcd_next;
                        d.bin = q.bin + 1'b1;
                    end
                    if (at_end) begin
                        d.busy  = 1'b0;
                        d.valid = 1'b1;
                        d.res   = d.bcd;
                        d.over  = 1'b1;
                        d.under = 1'b0;
                    end
                end
                if (at_end) begin
                    d.cyc = '0;
                    d.ph  = run_lvl ? PH_AZ : PH_HOLD;
                end
            end
            PH_ZERO: begin
                d.cyc = q.cyc + 1'b1;
                if (at_end) begin
                    d.cyc = '0;
                    d.ph  = run_lvl ? PH_AZ : PH_HOLD;
                end
            end
            PH_HOLD: begin
                d.cyc = '0;
                if (run_rise) d.ph = PH_AZ;
            end
            default: begin
                d.ph  = PH_HOLD;
                d.cyc = '0;
            end
        endcase

        d.sw = sw_of(d.ph);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q       <= '0;
            q.ph    <= PH_AZ;
            q.sw    <= sw_of(PH_AZ);
        end else begin
            q <= d;
        end
    end

    assign sw_az_o    = q.sw[SW_AZ];
    assign sw_int_o   = q.sw[SW_INT];
    assign sw_deint_o = q.sw[SW_DEINT];
    assign sw_zero_o  = q.sw[SW_ZERO];
    assign busy_o     = q.busy;
    assign pol_o      = q.pol;
    assign over_o     = q.over;
    assign under_o    = q.under;
    assign result_o   = q.res;
    assign valid_o    = q.valid;

endmodule

// File: rtl/ds_seq_chk.sv
module ds_seq_chk #(
    parameter int RES_W = 20
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sw_az_o,
    input logic             sw_int_o,
    input logic             sw_deint_o,
    input logic             sw_zero_o,
    input logic             busy_o,
    input logic             pol_o,
    input logic             over_o,
    input logic             under_o,
    input logic [RES_W-1:0] result_o,
    input logic             valid_o
);
    // R9
    switch_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({sw_az_o, sw_int_o, sw_deint_o, sw_zero_o}) == 1);

    // R4
    busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> sw_int_o);

    // R5
    valid_at_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (!busy_o && $past(busy_o)));

    // R5
    result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(result_o) |-> valid_o);

    // R3
    over_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(over_o) |-> valid_o);

    // R6
    over_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(over_o) |-> (sw_deint_o && $past(sw_int_o)));

    // R7
    under_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(under_o) |-> valid_o);

    // R8
    pol_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(pol_o) |-> (sw_deint_o && $past(sw_int_o)));

endmodule

bind ds_sequencer ds_seq_chk #(
    .RES_W(4 * RES_DIGITS)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_az_o    (sw_az_o),
    .sw_int_o   (sw_int_o),
    .sw_deint_o (sw_deint_o),
    .sw_zero_o  (sw_zero_o),
    .busy_o     (busy_o),
    .pol_o      (pol_o),
    .over_o     (over_o),
    .under_o    (under_o),
    .result_o   (result_o),
    .valid_o    (valid_o)
);

// File: tb/ds_sequencer_tb.sv
`timescale 1ns/1ps
module ds_sequencer_tb;
    localparam int AZ  = 11;
    localparam int IN  = 10;
    localparam int DM  = 21;
    localparam int UL  = 4;
    localparam int DG  = 5;
    localparam int CYC = AZ + IN + DM;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic cmp = 1'b0;
    logic sw_az_o, sw_int_o, sw_deint_o, sw_zero_o;
    logic busy_o, pol_o, over_o, under_o, valid_o;
    logic [4*DG-1:0] result_o;

    always #4 clk = ~clk;

    ds_sequencer #(
        .AZ_CLKS(AZ), .INT_CLKS(IN), .DEINT_MAX(DM),
        .UNDER_LIMIT(UL), .RES_DIGITS(DG), .SYNC_STAGES(2)
    ) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .run_i(run), .cmp_i(cmp),
        .sw_az_o(sw_az_o), .sw_int_o(sw_int_o), .sw_deint_o(sw_deint_o),
        .sw_zero_o(sw_zero_o), .busy_o(busy_o), .pol_o(pol_o),
        .over_o(over_o), .under_o(under_o), .result_o(result_o),
        .valid_o(valid_o)
    );

    typedef struct { int res; bit over; bit under; bit pol; } exp_t;
    exp_t exp_q[$];
    exp_t mon_e;

    int  checks = 0;
    int  errors = 0;
    int  int_rises = 0;
    bit  prev_pol = 1'b0;
    bit  prev_over = 1'b0;
    bit  valid_prev = 1'b0;
    bit  done = 1'b0;
    longint last_int_t = 0;

    function automatic void check(input bit ok, input string req, input string what,
                                  input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endfunction

    function automatic logic [4*DG-1:0] to_bcd(input int v);
        logic [4*DG-1:0] r;
        int x;
        r = '0;
        x = v;
        for (int i = 0; i < DG; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    always @(posedge sw_int_o) int_rises++;

    // Scoreboard monitor: pops one expected reading per valid pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_o) begin
                check(!valid_prev, "R5", "valid pulse width", 2, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "valid with nothing expected", 1, 0);
                end else begin
                    mon_e = exp_q.pop_front();
                    check(result_o == to_bcd(mon_e.res), "R2", "reading",
                          result_o, to_bcd(mon_e.res));
                    check(over_o == mon_e.over, "R3", "over flag", over_o, mon_e.over);
                    check(under_o == mon_e.under, "R7", "under flag", under_o, mon_e.under);
                    check(pol_o == mon_e.pol, "R8", "polarity", pol_o, mon_e.pol);
                end
            end
            valid_prev = valid_o;
        end
    end

    // n < 0: comparator never changes (over-range).
    task automatic do_cycle(input bit pol, input int n, input bit chk_len);
        exp_t e;
        int k;
        int ilen;
        int fall_k;
        e.res   = (n < 0) ? DM - 1 : n;
        e.over  = (n < 0);
        e.under = (n >= 0) && (n <= UL);
        e.pol   = pol;
        exp_q.push_back(e);
        do @(negedge clk); while (!sw_int_o);
        if (chk_len)
            check(($time - last_int_t) == CYC * 8, "R1", "cycle length",
                  ($time - last_int_t) / 8, CYC);
        last_int_t = $time;
        check(busy_o == 1'b1, "R4", "busy at integrate start", busy_o, 1);
        check(under_o == 1'b0, "R7", "under clear at integrate start", under_o, 0);
        check(pol_o == prev_pol, "R8", "polarity held in integrate", pol_o, prev_pol);
        check(over_o == prev_over, "R6", "over held in integrate", over_o, prev_over);
        cmp = pol;
        ilen = 0;
        while (!sw_deint_o && ilen < 4 * CYC) begin
            @(negedge clk);
            ilen++;
        end
        check(ilen == IN, "R1", "integrate length", ilen, IN);
        check(pol_o == pol, "R8", "polarity at deintegrate start", pol_o, pol);
        check(over_o == 1'b0, "R6", "over clear at deintegrate start", over_o, 0);
        k = 0;
        if (n == 0) cmp = ~pol;
        while (busy_o && k < 4 * CYC) begin
            @(negedge clk);
            k++;
            if (k == n) cmp = ~pol;
        end
        fall_k = (n < 0 || n + 2 > DM) ? DM : n + 2;
        check(k == fall_k, "R4", "busy fall clock", k, fall_k);
        check(valid_o == 1'b1, "R5", "valid with busy fall", valid_o, 1);
        if (fall_k < DM)
            check(sw_zero_o == 1'b1, "R9", "zeroing switch after crossing", sw_zero_o, 1);
        prev_pol  = pol;
        prev_over = (n < 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        check(sw_az_o && !sw_int_o && !sw_deint_o && !sw_zero_o, "R9",
              "reset switch pattern", {sw_az_o, sw_int_o, sw_deint_o, sw_zero_o}, 4'b1000);
        check(!busy_o && !valid_o && !over_o && !under_o, "R9", "reset flags",
              {busy_o, valid_o, over_o, under_o}, 0);
        check(result_o == '0, "R9", "reset reading", result_o, 0);
        rst_n = 1'b1;
        run   = 1'b1;

        do_cycle(1'b1, 5, 1'b0);
        do_cycle(1'b0, 3, 1'b1);
        do_cycle(1'b1, -1, 1'b1);
        do_cycle(1'b1, 0, 1'b1);
        do_cycle(1'b0, DM - 2, 1'b1);

        // R10: run drops during a cycle; the cycle completes, then idle.
        fork
            do_cycle(1'b1, 7, 1'b1);
            begin repeat (15) @(negedge clk); run = 1'b0; end
        join
        repeat (60) @(negedge clk);
        r0 = int_rises;
        repeat (150) @(negedge clk);
        check(int_rises == r0, "R10", "no integration while held", int_rises, r0);
        check(sw_az_o == 1'b1, "R10", "auto-zero while held", sw_az_o, 1);
        check(result_o == to_bcd(7), "R10", "reading held", result_o, to_bcd(7));
        check(!busy_o, "R10", "busy low while held", busy_o, 0);

        // R11: a pulse in idle starts exactly one cycle.
        r0 = int_rises;
        run = 1'b1;
        repeat (3) @(negedge clk);
        run = 1'b0;
        do_cycle(1'b0, 2, 1'b0);
        // R11: a pulse inside the running cycle is ignored.
        run = 1'b1;
        repeat (3) @(negedge clk);
        run = 1'b0;
        repeat (150) @(negedge clk);
        check(int_rises == r0 + 1, "R11", "single cycle from idle pulse", int_rises, r0 + 1);
        check(sw_az_o == 1'b1, "R11", "idle after pulse in cycle", sw_az_o, 1);
        check(exp_q.size() == 0, "R5", "all readings delivered", exp_q.size(), 0);
        finish_run();
    end

endmodule